// File: doc/BRIEF.md
# Interrupt Request Flag Detector

This block is a single request channel of an interrupt controller. It watches one request line that has already been brought into the controller's clock domain, detects the condition chosen by a 2-bit detection mode, and holds the result in a pending flag. The flag is what the priority resolver sees, qualified by a separate enable bit, and it is also what software reads when it polls the channel with the enable bit off.

The flag is cleared in two ways. The resolver's acknowledge clears it when the mode is edge-based. A software write of 0 also clears it. A fresh detection always beats a clear that arrives in the same cycle, so no event is dropped. In level mode the acknowledge is ignored. The flag cannot be cleared while the line is still asserted, because the active level sets it again at once. The enable bit only gates the request toward the resolver. It never alters the flag.

Top module: `irq_flag_detector`

## Requirements
- R1: During and right after a synchronous reset, `pend_flag` and `resolver_req` are 0.
- R2: With `det_mode` = 2'b01 (falling edge), a 1-to-0 change of `src_n` sets `pend_flag` on the following clock edge. A 0-to-1 change does not set it.
- R3: With `det_mode` = 2'b10 (rising edge), a 0-to-1 change of `src_n` sets `pend_flag` on the following clock edge. A 1-to-0 change does not set it.
- R4: With `det_mode` = 2'b11 (both edges), either change of `src_n` sets `pend_flag` on the following clock edge.
- R5: In any edge mode (`det_mode` != 2'b00), a cycle with `vec_ack` = 1 and no new edge clears `pend_flag` at the next clock edge.
- R6: With `det_mode` = 2'b00 (low level), `pend_flag` is set while `src_n` is 0, and `vec_ack` never clears it.
- R7: In low-level mode a software write of 0 (`sw_we` = 1, `sw_wdata` = 0) has no effect while `src_n` is 0. Once `src_n` is 1, the same write clears the flag.
- R8: In edge modes a software write of 0 clears `pend_flag`. A software write of 1 never sets it.
- R9: `resolver_req` equals `pend_flag` AND `irq_en`. Changing `irq_en` in either direction leaves `pend_flag` unchanged.
- R10: A new edge in the same cycle as an acknowledge or a software clear leaves `pend_flag` set.
- R11: After reset the previous-sample register holds the idle level (1). If `src_n` is held at 1 through and after reset, no edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_n | input | 1 | Synchronized request line, active low in level mode |
| det_mode | input | 2 | Detection mode: 00 low, 01 fall, 10 rise, 11 both |
| irq_en | input | 1 | Enable bit toward the resolver |
| sw_we | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Software write value; 0 requests a clear |
| vec_ack | input | 1 | Resolver acknowledge: this channel's vector was taken |
| pend_flag | output | 1 | Pending request flag, readable by software |
| resolver_req | output | 1 | Request to the priority resolver |

## Verification
The hardest case to reach is a new edge that lands in exactly the cycle an acknowledge or a software clear is applied. The flag must already be set, and the line must change state in the same cycle as the clear. The stimulus first sets the flag in both-edge mode. It then toggles `src_n` together with `vec_ack` in one step, and together with a software 0-write in another, and expects the flag to stay at 1 after each. A second delicate case is level mode with the line still low. A clear that would succeed in edge mode must have no visible effect here. The bench checks this before and after releasing the line.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_FALL = 2'b01,
        DET_RISE = 2'b10,
        DET_BOTH = 2'b11
    } det_mode_e;

    typedef struct packed {
        logic set;     // detection event this cycle
        logic sw_clr;  // software wrote 0
        logic ack;     // resolver took the vector
    } flag_ctl_t;

    function automatic logic mode_is_edge(det_mode_e m);
        return m != DET_LOW;
    endfunction

    function automatic logic detect_hit(det_mode_e m, logic prev, logic cur);
        logic hit;
        unique case (m)
            DET_LOW:  hit = !cur;
            DET_FALL: hit = prev && !cur;
            DET_RISE: hit = !prev && cur;
            default:  hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler
    import irq_flag_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  det_mode_e mode,
    input  logic      line,
    output logic      hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LEVEL;
        else     prev_q <= line;
    end

    always_comb hit = !rst && detect_hit(mode, prev_q, line);

endmodule

// File: rtl/irq_pend_flag.sv
module irq_pend_flag
    import irq_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  det_mode_e mode,
    input  flag_ctl_t ctl,
    output logic      flag
);

    logic flag_q;
    logic clr;

    always_comb clr = ctl.sw_clr || (ctl.ack && mode_is_edge(mode));

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (ctl.set) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl.set |=> flag_q); // R10

    AST_EDGE_ACK_CLR: assert property (@(posedge clk) disable iff (rst)
        (mode != DET_LOW && ctl.ack && !ctl.set) |=> !flag_q); // R5

    AST_LEVEL_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == DET_LOW && flag_q && !ctl.sw_clr) |=> flag_q); // R6

    AST_SW_CLR: assert property (@(posedge clk) disable iff (rst)
        (ctl.sw_clr && !ctl.set) |=> !flag_q); // R8

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctl.set && !ctl.sw_clr && !ctl.ack) |=> $stable(flag_q)); // R9

endmodule

// File: rtl/irq_flag_detector.sv
module irq_flag_detector
    import irq_flag_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_n,
    input  logic [1:0] det_mode,
    input  logic       irq_en,
    input  logic       sw_we,
    input  logic       sw_wdata,
    input  logic       vec_ack,
    output logic       pend_flag,
    output logic       resolver_req
);

    det_mode_e mode;
    logic      hit;
    flag_ctl_t ctl;

    always_comb mode = det_mode_e'(det_mode);

    irq_line_sampler #(.IDLE_LEVEL(IDLE_LEVEL)) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .line (src_n),
        .hit  (hit)
    );

    always_comb begin
        ctl.set    = hit;
        ctl.sw_clr = sw_we && !sw_wdata;
        ctl.ack    = vec_ack;
    end

    irq_pend_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .ctl  (ctl),
        .flag (pend_flag)
    );

    assign resolver_req = pend_flag && irq_en;

endmodule

// File: tb/irq_flag_detector_test.sv
module irq_flag_detector_test;

    typedef struct {
        logic  f;
        logic  r;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       src_n;
    logic [1:0] det_mode;
    logic       irq_en;
    logic       sw_we;
    logic       sw_wdata;
    logic       vec_ack;
    logic       pend_flag;
    logic       resolver_req;

    int   errors = 0;
    int   checks = 0;
    bit   done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_flag_detector uut (
        .clk(clk), .rst(rst), .src_n(src_n), .det_mode(det_mode),
        .irq_en(irq_en), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .vec_ack(vec_ack), .pend_flag(pend_flag), .resolver_req(resolver_req)
    );

    // driver: one call per clock, pushes what the outputs must show after the edge
    task automatic cyc(input logic r, input logic line, input logic [1:0] m,
                       input logic en, input logic we, input logic wd,
                       input logic ak, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; src_n = line; det_mode = m; irq_en = en;
        sw_we = we; sw_wdata = wd; vec_ack = ak;
        e.f = ef; e.r = ef && en; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pend_flag !== e.f || resolver_req !== e.r) begin
                    errors++;
                    $display("FAIL %s: flag=%b req=%b expected flag=%b req=%b",
                             e.tag, pend_flag, resolver_req, e.f, e.r);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        cyc(1, 1, 2'b01, 1, 0, 0, 0, 0, "R1 reset");
        cyc(1, 1, 2'b01, 1, 0, 0, 0, 0, "R1 reset");
        // R11 idle line after reset gives no edge
        cyc(0, 1, 2'b01, 1, 0, 0, 0, 0, "R11 idle");
        cyc(0, 1, 2'b01, 1, 0, 0, 0, 0, "R11 idle");
        // R2 falling edge
        cyc(0, 0, 2'b01, 1, 0, 0, 0, 1, "R2 fall sets");
        cyc(0, 0, 2'b01, 1, 0, 0, 0, 1, "R2 hold");
        cyc(0, 0, 2'b01, 1, 0, 0, 1, 0, "R5 ack clears fall");
        cyc(0, 0, 2'b01, 1, 0, 0, 0, 0, "R2 low no edge");
        cyc(0, 1, 2'b01, 1, 0, 0, 0, 0, "R2 rise ignored");
        // R9 enable toggles
        cyc(0, 1, 2'b01, 0, 0, 0, 0, 0, "R9 en off flag0");
        cyc(0, 1, 2'b01, 1, 0, 0, 0, 0, "R9 en on flag0");
        cyc(0, 0, 2'b01, 0, 0, 0, 0, 1, "R9 set with en off");
        cyc(0, 0, 2'b01, 1, 0, 0, 0, 1, "R9 en on flag1");
        cyc(0, 0, 2'b01, 0, 0, 0, 0, 1, "R9 en off flag1");
        // R8 software writes
        cyc(0, 0, 2'b01, 1, 1, 1, 0, 1, "R8 write1 keeps");
        cyc(0, 0, 2'b01, 1, 1, 0, 0, 0, "R8 write0 clears");
        cyc(0, 0, 2'b01, 1, 1, 1, 0, 0, "R8 write1 no set");
        // R3 rising edge
        cyc(0, 1, 2'b10, 1, 0, 0, 0, 1, "R3 rise sets");
        cyc(0, 1, 2'b10, 1, 0, 0, 1, 0, "R5 ack clears rise");
        cyc(0, 0, 2'b10, 1, 0, 0, 0, 0, "R3 fall ignored");
        // R4 both edges
        cyc(0, 1, 2'b11, 1, 0, 0, 0, 1, "R4 rise sets");
        cyc(0, 1, 2'b11, 1, 0, 0, 1, 0, "R5 ack clears both");
        cyc(0, 0, 2'b11, 1, 0, 0, 0, 1, "R4 fall sets");
        cyc(0, 0, 2'b11, 1, 0, 0, 1, 0, "R5 ack clears both");
        // R10 edge with a clear in the same cycle
        cyc(0, 1, 2'b11, 1, 0, 0, 0, 1, "R10 setup");
        cyc(0, 0, 2'b11, 1, 0, 0, 1, 1, "R10 edge beats ack");
        cyc(0, 1, 2'b11, 1, 1, 0, 0, 1, "R10 edge beats sw clear");
        cyc(0, 1, 2'b11, 1, 0, 0, 1, 0, "R5 ack alone clears");
        // R6 level mode
        cyc(0, 1, 2'b00, 1, 0, 0, 0, 0, "R6 inactive level");
        cyc(0, 0, 2'b00, 1, 0, 0, 0, 1, "R6 low sets");
        cyc(0, 0, 2'b00, 1, 0, 0, 1, 1, "R6 ack ignored low");
        cyc(0, 1, 2'b00, 1, 0, 0, 1, 1, "R6 ack ignored high");
        // R7 level clear rules
        cyc(0, 0, 2'b00, 1, 1, 0, 0, 1, "R7 clear blocked low");
        cyc(0, 1, 2'b00, 1, 1, 0, 0, 0, "R7 clear after release");
        cyc(0, 1, 2'b00, 1, 0, 0, 0, 0, "R7 stays clear");
        // drain
        @(negedge clk);
        sw_we = 0; vec_ack = 0;
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule